// File: doc/BRIEF.md
# Dual-Queue FIFO with Mark and Retransmit

This block is a single-clock FIFO controller around an internal register-array store. The store is used either as one queue spanning every location, or split into two equal halves that behave as two independent queues, each with its own write pointer, read pointer and mark position. A write port selects its queue with a select bit. A read port selects its queue with another select bit, and it also has an output enable, a mark strobe and a retransmit strobe.

Accepted reads with the output enable high load the output register. In the same cycle they pull the active-low data-valid line of the queue that was read. A read with the output enable low still consumes the word but leaves the output untouched; this is the read-skip case. A mark taken together with a read records that read's location. A later retransmit rewinds the queue's read pointer to the recorded location, so the stored data can be replayed. The full flag follows the write-selected queue and the empty flag follows the read-selected queue. Both flags are active low.

Top module: `dualq_fifo`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) clears all pointers and mark positions and sets `rd_data` to zero. It then leaves `dval_n` = 2'b11, `empty_n` = 0 and `full_n` = 1.
- R2: With `dual_mode` = 0, the whole store of DEPTH words is one queue (queue 0). Words are read back in write order, and `full_n` drops only after DEPTH unread words are held.
- R3: With `dual_mode` = 1, queue 0 occupies the lower DEPTH/2 words and queue 1 the upper DEPTH/2 words. A select bit of 0 picks queue 0 and 1 picks queue 1. Each queue fills, empties and orders its data independently.
- R4: With `dual_mode` = 0, a write with `wr_qsel` = 1 and a read, mark or retransmit with `rd_qsel` = 1 are ignored. Both flags then report queue 0.
- R5: `full_n` is low exactly when the queue chosen by `wr_qsel` is full. A write to a full queue is dropped even if a read of that queue happens in the same cycle.
- R6: `empty_n` is low exactly when the queue chosen by `rd_qsel` is empty. A read of an empty queue is dropped and changes no output, even if a write to that queue happens in the same cycle.
- R7: An accepted read with `rd_oe` = 0 advances the read pointer but leaves `rd_data` unchanged and `dval_n` high.
- R8: An accepted read with `rd_oe` = 1 places the word on `rd_data` one clock after the edge that takes it. In that same cycle it drives `dval_n[q]` low for one cycle, where bit 0 belongs to queue 0 and bit 1 to queue 1. At most one bit of `dval_n` is low.
- R9: `mark` asserted with an accepted read stores that read's location for the selected queue. A `rexmit` cycle moves the read pointer to the stored location and ignores any read in that cycle. Later reads replay from there, including words written after the rewind, until the queue is empty.
- R10: A retransmit with no mark taken since reset returns the read pointer to the first location of the queue.
- R11: A write and a read on the same queue in one cycle both take effect when neither flag blocks them, and the occupancy stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Synchronous reset, active low |
| dual_mode | input | 1 | 0: one queue, 1: two half-size queues; change only during reset |
| wr_en | input | 1 | Write request |
| wr_qsel | input | 1 | Queue picked for writes |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request |
| rd_qsel | input | 1 | Queue picked for reads, mark and retransmit |
| rd_oe | input | 1 | 1: present read data, 0: skip (consume only) |
| mark | input | 1 | Record the location of the current read |
| rexmit | input | 1 | Rewind the read pointer to the recorded location |
| rd_data | output | DATA_W | Registered read data |
| dval_n | output | 2 | Per-queue data-valid, active low |
| full_n | output | 1 | Write-selected queue full, active low |
| empty_n | output | 1 | Read-selected queue empty, active low |

## Verification
The bench builds the block with DATA_W = 8 and DEPTH = 8, so each half holds four words. With that size, a queue fills to its limit in a handful of writes in both modes, and the wrap bit toggles within the test. The small halves also make it easy to see that one queue filling leaves the other's flags alone. A further sequence runs a mark, a read skip, an empty-blocked read, a rewind and a replay that reaches words written after the rewind.

// File: rtl/dq_pkg.sv
// Shared definitions for the dual-queue FIFO.
// Assumes: exactly two queue slots exist; queue 1 is idle in single mode.
package dq_pkg;
    localparam int QN = 2;

    typedef enum logic {
        Q_SINGLE = 1'b0,
        Q_DUAL   = 1'b1
    } qmode_e;
endpackage

// File: rtl/dq_store.sv
// Register-array word store with one write port and one asynchronous read port.
// Assumes: the caller never reads a location in the cycle it writes it.
module dq_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Store the incoming word on a write strobe.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Present the addressed word to the output register.
    assign rdata = mem[raddr];
endmodule

// File: rtl/dq_queue_ctl.sv
// Pointer set for one queue: write, read and mark offsets, each with a wrap bit.
// Offsets count 0..last_off and then wrap; full and empty are decided
// from the offset and wrap bit pairs.
// Assumes: wr_go and rd_go are only raised when the matching flag allows it,
// and last_off changes only while in reset.
module dq_queue_ctl #(
    parameter int OFF_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OFF_W-1:0] last_off,
    input  logic             wr_go,
    input  logic             rd_go,
    input  logic             mark_go,
    input  logic             rexmit_go,
    output logic [OFF_W-1:0] wr_off,
    output logic [OFF_W-1:0] rd_off,
    output logic             full,
    output logic             empty
);
    logic             wr_wrap, rd_wrap, mk_wrap;
    logic [OFF_W-1:0] mk_off;

    // Advance or rewind the pointers; mark captures the read location.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_off  <= '0;
            wr_wrap <= 1'b0;
            rd_off  <= '0;
            rd_wrap <= 1'b0;
            mk_off  <= '0;
            mk_wrap <= 1'b0;
        end else begin
            if (wr_go) begin
                if (wr_off == last_off) begin
                    wr_off  <= '0;
                    wr_wrap <= ~wr_wrap;
                end else begin
                    wr_off <= wr_off + 1'b1;
                end
            end
            if (rexmit_go) begin
                rd_off  <= mk_off;
                rd_wrap <= mk_wrap;
            end else if (rd_go) begin
                if (rd_off == last_off) begin
                    rd_off  <= '0;
                    rd_wrap <= ~rd_wrap;
                end else begin
                    rd_off <= rd_off + 1'b1;
                end
            end
            if (mark_go && !rexmit_go) begin
                mk_off  <= rd_off;
                mk_wrap <= rd_wrap;
            end
        end
    end

    // Decide the flags from the pointer pairs.
    assign full  = (wr_off == rd_off) && (wr_wrap != rd_wrap);
    assign empty = (wr_off == rd_off) && (wr_wrap == rd_wrap);

    // Occupancy, used only by the checks below.
    logic [OFF_W:0] occ, cap;
    always_comb begin
        cap = {1'b0, last_off} + 1'b1;
        if (wr_wrap == rd_wrap) occ = {1'b0, wr_off} - {1'b0, rd_off};
        else                    occ = cap - {1'b0, rd_off} + {1'b0, wr_off};
    end

    AST_RESET_EMPTY: assert property (@(posedge clk)
        !rst_n |=> (empty && !full)); // R1
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= cap); // R5
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !rexmit_go) |=> $stable(rd_off)); // R6
    AST_RETX_TO_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        rexmit_go |=> (rd_off == $past(mk_off) && rd_wrap == $past(mk_wrap))); // R9
endmodule

// File: rtl/dualq_fifo.sv
// Single-clock FIFO whose store acts as one queue or as two half-size queues.
// Each queue has its own pointer set; the read side supports skip,
// mark and retransmit, and a registered output with per-queue valid strobes.
// Assumes: DEPTH is a power of two of at least 4; dual_mode changes only in reset.
module dualq_fifo
    import dq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dual_mode,
    input  logic              wr_en,
    input  logic              wr_qsel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              rd_qsel,
    input  logic              rd_oe,
    input  logic              mark,
    input  logic              rexmit,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        dval_n,
    output logic              full_n,
    output logic              empty_n
);
    localparam int AW   = $clog2(DEPTH);
    localparam int HALF = DEPTH / 2;
    localparam logic [AW-1:0] LAST_ALL  = AW'(DEPTH - 1);
    localparam logic [AW-1:0] LAST_HALF = AW'(HALF - 1);
    localparam logic [AW-1:0] BASE_HI   = AW'(HALF);

    qmode_e mode;
    logic   wsel, rsel, wsel_ok, rsel_ok;
    logic [QN-1:0] wr_go, rd_go, mark_go, rx_go, full_q, empty_q;
    logic [AW-1:0] wr_off_q [QN];
    logic [AW-1:0] rd_off_q [QN];
    logic [AW-1:0] last_q   [QN];
    logic [AW-1:0] waddr, raddr;
    logic [DATA_W-1:0] mem_rd;

    // Resolve the mode and the effective queue selects.
    assign mode    = dual_mode ? Q_DUAL : Q_SINGLE;
    assign wsel_ok = (mode == Q_DUAL) || !wr_qsel;
    assign rsel_ok = (mode == Q_DUAL) || !rd_qsel;
    assign wsel    = (mode == Q_DUAL) ? wr_qsel : 1'b0;
    assign rsel    = (mode == Q_DUAL) ? rd_qsel : 1'b0;

    // One pointer set per queue slot, with its own strobes.
    for (genvar q = 0; q < QN; q++) begin : g_q
        assign last_q[q]  = (q == 0 && mode == Q_SINGLE) ? LAST_ALL : LAST_HALF;
        assign wr_go[q]   = wr_en && wsel_ok && (wr_qsel == 1'(q)) && !full_q[q];
        assign rx_go[q]   = rexmit && rsel_ok && (rd_qsel == 1'(q));
        assign rd_go[q]   = rd_en && rsel_ok && (rd_qsel == 1'(q)) && !empty_q[q]
                            && !rx_go[q];
        assign mark_go[q] = mark && rd_go[q];

        dq_queue_ctl #(.OFF_W(AW)) u_ctl (
            .clk       (clk),
            .rst_n     (rst_n),
            .last_off  (last_q[q]),
            .wr_go     (wr_go[q]),
            .rd_go     (rd_go[q]),
            .mark_go   (mark_go[q]),
            .rexmit_go (rx_go[q]),
            .wr_off    (wr_off_q[q]),
            .rd_off    (rd_off_q[q]),
            .full      (full_q[q]),
            .empty     (empty_q[q])
        );
    end

    // Map queue offsets onto physical store addresses.
    assign waddr = (wsel ? BASE_HI : '0) + wr_off_q[wsel];
    assign raddr = (rsel ? BASE_HI : '0) + rd_off_q[rsel];

    dq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (|wr_go),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (mem_rd)
    );

    // Output register and valid strobes; skipped reads leave them alone.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            dval_n  <= 2'b11;
        end else begin
            dval_n <= 2'b11;
            if ((|rd_go) && rd_oe) begin
                rd_data      <= mem_rd;
                dval_n[rsel] <= 1'b0;
            end
        end
    end

    // Flags follow the queue each port has selected.
    assign full_n  = !full_q[wsel];
    assign empty_n = !empty_q[rsel];

    AST_DVAL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~dval_n)); // R8
    AST_SKIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_oe) |=> ($stable(rd_data) && dval_n == 2'b11)); // R7
    AST_SINGLE_Q1_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == Q_SINGLE) |-> !(wr_go[1] || rd_go[1])); // R4
endmodule

// File: tb/tb_dualq_fifo.sv
`timescale 1ns/1ps
module tb_dualq_fifo;
    localparam int DW = 8;
    localparam int DP = 8;

    logic clk = 1'b0, rst_n = 1'b0, dual_mode = 1'b0;
    logic wr_en = 0, wr_qsel = 0, rd_en = 0, rd_qsel = 0, rd_oe = 0, mark = 0, rexmit = 0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic [1:0] dval_n;
    logic full_n, empty_n;
    int checks = 0, errors = 0, cycles = 0;

    always #2 clk = ~clk;

    dualq_fifo #(.DATA_W(DW), .DEPTH(DP)) dut (
        .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode),
        .wr_en(wr_en), .wr_qsel(wr_qsel), .wr_data(wr_data),
        .rd_en(rd_en), .rd_qsel(rd_qsel), .rd_oe(rd_oe),
        .mark(mark), .rexmit(rexmit),
        .rd_data(rd_data), .dval_n(dval_n), .full_n(full_n), .empty_n(empty_n)
    );

    typedef struct packed {
        logic [23:0] tag;
        logic        we, wq;
        logic [7:0]  wd;
        logic        re, rq, oe, mk, rt;
        logic [7:0]  xd;
        logic [1:0]  xdv;
        logic        xfn, xen;
    } vec_t;

    // Single-queue sequence; expectations hold after the edge, inputs still applied.
    localparam vec_t VEC [13] = '{
        '{"R2 ", 1,0,8'h11, 0,0,0,0,0, 8'h00,2'b11,1,1},
        '{"R2 ", 1,0,8'h22, 0,0,0,0,0, 8'h00,2'b11,1,1},
        '{"R2 ", 1,0,8'h33, 0,0,0,0,0, 8'h00,2'b11,1,1},
        '{"R8 ", 0,0,8'h00, 1,0,1,0,0, 8'h11,2'b10,1,1},
        '{"R9 ", 0,0,8'h00, 1,0,1,1,0, 8'h22,2'b10,1,1},
        '{"R7 ", 0,0,8'h00, 1,0,0,0,0, 8'h22,2'b11,1,0},
        '{"R6 ", 0,0,8'h00, 1,0,1,0,0, 8'h22,2'b11,1,0},
        '{"R9 ", 0,0,8'h00, 0,0,0,0,1, 8'h22,2'b11,1,1},
        '{"R11", 1,0,8'h44, 1,0,1,0,0, 8'h22,2'b10,1,1},
        '{"R9 ", 0,0,8'h00, 1,0,1,0,0, 8'h33,2'b10,1,1},
        '{"R9 ", 0,0,8'h00, 1,0,1,0,0, 8'h44,2'b10,1,0},
        '{"R4 ", 1,1,8'h55, 0,0,0,0,0, 8'h44,2'b11,1,0},
        '{"R4 ", 0,0,8'h00, 1,1,1,0,0, 8'h44,2'b11,1,0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic we, input logic wq, input logic [7:0] wd,
                       input logic re, input logic rq, input logic oe,
                       input logic mk, input logic rt);
        wr_en = we; wr_qsel = wq; wr_data = wd;
        rd_en = re; rd_qsel = rq; rd_oe = oe; mark = mk; rexmit = rt;
        @(negedge clk);
    endtask

    task automatic do_reset(input logic dual);
        rst_n = 1'b0; dual_mode = dual;
        cyc(0,0,0, 0,0,0,0,0);
        cyc(0,0,0, 0,0,0,0,0);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        do_reset(1'b0);
        // R1: reset state
        chk("R1 data", rd_data, 0);
        chk("R1 dval", dval_n, 2'b11);
        chk("R1 empty", empty_n, 0);
        chk("R1 full", full_n, 1);

        // Table walk: mark, skip, empty block, rewind, replay, ignored selects.
        for (int i = 0; i < 13; i++) begin
            cyc(VEC[i].we, VEC[i].wq, VEC[i].wd, VEC[i].re, VEC[i].rq,
                VEC[i].oe, VEC[i].mk, VEC[i].rt);
            chk($sformatf("%s data v%0d", VEC[i].tag, i), rd_data, VEC[i].xd);
            chk($sformatf("%s dval v%0d", VEC[i].tag, i), dval_n, VEC[i].xdv);
            chk($sformatf("%s full v%0d", VEC[i].tag, i), full_n, VEC[i].xfn);
            chk($sformatf("%s empty v%0d", VEC[i].tag, i), empty_n, VEC[i].xen);
        end

        // R2 R5: fill the single queue, drop the extra write, drain in order.
        do_reset(1'b0);
        for (int i = 0; i < DP; i++) begin
            cyc(1,0,8'h80 + 8'(i), 0,0,0,0,0);
            chk("R5 full", full_n, (i == DP - 1) ? 0 : 1);
        end
        cyc(1,0,8'hEE, 0,0,0,0,0);
        chk("R5 full held", full_n, 0);
        for (int i = 0; i < DP; i++) begin
            cyc(0,0,0, 1,0,1,0,0);
            chk("R2 order", rd_data, 8'h80 + 8'(i));
            chk("R8 dval q0", dval_n, 2'b10);
        end
        chk("R6 empty", empty_n, 0);
        cyc(0,0,0, 1,0,1,0,0);
        chk("R6 dropped read", dval_n, 2'b11);
        chk("R5 no extra word", rd_data, 8'h87);

        // R3: two halves of four words each.
        do_reset(1'b1);
        for (int i = 0; i < DP / 2; i++) cyc(1,1,8'hA0 + 8'(i), 0,0,0,0,0);
        chk("R3 q1 full", full_n, 0);
        cyc(0,0,0, 0,0,0,0,0);
        chk("R3 q0 not full", full_n, 1);
        chk("R3 q0 empty", empty_n, 0);
        cyc(1,0,8'hC0, 0,1,0,0,0);
        chk("R3 q1 not empty", empty_n, 1);
        for (int i = 0; i < DP / 2; i++) begin
            cyc(0,0,0, 1,1,1,0,0);
            chk("R3 q1 order", rd_data, 8'hA0 + 8'(i));
            chk("R8 dval q1", dval_n, 2'b01);
        end
        chk("R3 q1 drained", empty_n, 0);
        cyc(0,0,0, 1,0,1,0,0);
        chk("R3 q0 data", rd_data, 8'hC0);
        chk("R8 dval q0 dual", dval_n, 2'b10);

        // R10: rewind with no mark goes to the queue base.
        do_reset(1'b0);
        for (int i = 0; i < 3; i++) cyc(1,0,8'h05 + 8'(i), 0,0,0,0,0);
        for (int i = 0; i < 3; i++) cyc(0,0,0, 1,0,1,0,0);
        cyc(0,0,0, 0,0,0,0,1);
        chk("R10 not empty", empty_n, 1);
        cyc(0,0,0, 1,0,1,0,0);
        chk("R10 base word", rd_data, 8'h05);

        // R5: at full, a same-cycle write is dropped while the read proceeds.
        do_reset(1'b0);
        for (int i = 0; i < DP; i++) cyc(1,0,8'h40 + 8'(i), 0,0,0,0,0);
        cyc(1,0,8'hF0, 1,0,1,0,0);
        chk("R5 read at full", rd_data, 8'h40);
        chk("R5 write dropped", full_n, 1);
        for (int i = 1; i < DP; i++) cyc(0,0,0, 1,0,1,0,0);
        chk("R5 last old word", rd_data, 8'h47);
        chk("R5 nothing extra", empty_n, 0);

        // R11: simultaneous write and read keep occupancy.
        do_reset(1'b0);
        cyc(1,0,8'h61, 0,0,0,0,0);
        cyc(1,0,8'h62, 1,0,1,0,0);
        chk("R11 read", rd_data, 8'h61);
        chk("R11 occupancy", empty_n, 1);
        cyc(0,0,0, 1,0,1,0,0);
        chk("R11 written word", rd_data, 8'h62);
        chk("R11 drained", empty_n, 0);

        finish_run();
    end
endmodule